// File: doc/BRIEF.md
# Serial EEPROM Slave with Density-Dependent Device Select

This block is the bus-facing front end of a small two-wire serial EEPROM. It watches oversampled clock and data lines in the system clock domain, recognises bus START and STOP conditions, and takes in a device-select byte. Every device-select byte carries a fixed four-bit type code, three device-select bits and a read/write flag. A parameter splits the three select bits into two groups. The upper bits are compared against strap pins. The lower bits choose which 256-byte block of the internal array is accessed. With more block bits the device is bigger, and fewer copies of it can share one bus.

After a matching write-type select, the next byte sets the byte pointer inside the chosen block. Each byte after that is stored at the pointer, and the pointer then advances, wrapping within the block. A read-type select streams bytes from the pointer for as long as the master acknowledges. A write-protect input makes the whole array read-only. The block only ever pulls the data line low or lets it float.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START is SDA falling while SCL is high. Until a START has been seen, clocked bytes get no acknowledge and SDA is never pulled low.
- R2: A STOP is SDA rising while SCL is high. A STOP ends any transfer, releases SDA and returns to idle. A write transfer cut short by a STOP keeps the byte pointer it was given.
- R3: A device-select byte is accepted only if bits 7:4 equal 4'b1010. Bit 0 = 1 selects a read and bit 0 = 0 selects a write.
- R4: Bits 3:1 of the select byte are A2, A1 and A0. With BLK_BITS = b, the top 3-b of these must equal the matching pins_i bits, and the low b bits select the 256-byte block. A select byte that does not match gets no acknowledge, and SDA stays released until the next START.
- R5: A matching select byte is acknowledged by pulling SDA low for the whole ninth SCL pulse.
- R6: After a write-type select, the next byte is loaded as the byte pointer and acknowledged. Every following byte is acknowledged and stored at the pointer, and the pointer then advances. Address 0xFF wraps to 0x00 in the same block.
- R7: A read-type select sends the byte at the pointer, MSB first, with each bit set up while SCL is low. The pointer then advances. Another byte follows only if the master acknowledges. After a master non-acknowledge, SDA is released and the slave goes idle.
- R8: While wp_i is high, data bytes are still acknowledged, but the array contents stay unchanged.
- R9: SDA is only pulled low (sda_oe_o = 1) or released (sda_oe_o = 0). sda_oe_o only turns on while the synchronised SCL is low.
- R10: After reset the slave is idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pins_i | input | 3 | Strap pins, bit 2 = A2 down to bit 0 = A0 |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| sda_oe_o | output | 1 | Pulls SDA low when high, releases it when low |

## Verification
Two of the block's functions can land on the same SCL falling edge. The last data bit of a write byte stores the byte in the array. That same edge advances the pointer and turns on the acknowledge drive. The bench writes across the 0xFF-to-0x00 wrap and reads the bytes back through a random-address read, which shows whether the store used the pointer value from before the advance. On the read side, the edge that ends a byte both advances the pointer and releases SDA, and the next byte must come from the new address. Random multi-byte reads are compared against a bench-side model of the array for this.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock stays high are framing, never data
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_dev_match.sv
module i2c_dev_match import i2c_ee_pkg::*; #(
  parameter int BLK_BITS = 1,
  localparam int BLK_W   = (BLK_BITS > 0) ? BLK_BITS : 1
) (
  input  logic [7:0]       sel_byte,
  input  logic [2:0]       pins,
  output logic             hit,
  output logic [BLK_W-1:0] blk
);
  localparam logic [2:0] BLK_MASK = 3'((1 << BLK_BITS) - 1);
  localparam logic [2:0] PIN_MASK = ~BLK_MASK;

  logic [2:0] dev;
  assign dev = sel_byte[3:1];
  assign hit = (sel_byte[7:4] == DEV_TYPE) && (((dev ^ pins) & PIN_MASK) == 3'b000);

  generate
    if (BLK_BITS > 0) begin : g_blk
      assign blk = dev[BLK_W-1:0];
    end else begin : g_noblk
      assign blk = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave import i2c_ee_pkg::*; #(
  parameter int BLK_BITS    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] pins_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int ADDR_W = 8 + BLK_BITS;
  localparam int BLK_W  = (BLK_BITS > 0) ? BLK_BITS : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic hit;
  logic [BLK_W-1:0] blk, ptr_blk;
  logic [7:0] sh, ptr_lo, rdata;
  logic [3:0] cnt;
  logic m_ack;
  logic mem_we;
  logic [ADDR_W-1:0] mem_addr;
  ee_state_e state, ack_next;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_dev_match #(.BLK_BITS(BLK_BITS)) u_match (
    .sel_byte(sh), .pins(pins_i), .hit(hit), .blk(blk)
  );

  generate
    if (BLK_BITS > 0) begin : g_addr_blk
      assign mem_addr = {ptr_blk, ptr_lo};
    end else begin : g_addr_flat
      assign mem_addr = ptr_lo;
    end
  endgenerate

  assign mem_we = (state == ST_WDATA) && scl_fall && (cnt == 4'd8) && !wp_i;

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(sh),
    .raddr(mem_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      cnt      <= 4'd0;
      sh       <= 8'h00;
      ptr_lo   <= 8'h00;
      ptr_blk  <= '0;
      m_ack    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_DEV;
      cnt      <= 4'd0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= 4'd0;
            if (state == ST_DEV) begin
              if (hit) begin
                sda_oe_o <= 1'b1;
                ptr_blk  <= blk;
                ack_next <= sh[0] ? ST_RDATA : ST_WADDR;
                state    <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (state == ST_WADDR) ptr_lo <= sh;
              else                   ptr_lo <= ptr_lo + 8'd1;
              sda_oe_o <= 1'b1;
              ack_next <= ST_WDATA;
              state    <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= 4'd0;
            if (ack_next == ST_RDATA) begin
              sh       <= rdata;
              sda_oe_o <= ~rdata[7];
            end else begin
              sda_oe_o <= 1'b0;
            end
            state <= ack_next;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe_o <= 1'b0;
              ptr_lo   <= ptr_lo + 8'd1;
              state    <= ST_RACK;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_oe_o <= ~sh[6];
              cnt      <= cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall) begin
            if (m_ack) begin
              sh       <= rdata;
              sda_oe_o <= ~rdata[7];
              cnt      <= 4'd0;
              state    <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_start_enters_select_R1: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_DEV));

  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (state == ST_IDLE && !sda_oe_o));

  assert_mismatch_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV && scl_fall && cnt == 4'd8 && !hit) |=> (state == ST_IDLE && !sda_oe_o));

  assert_bitcount_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= 4'd8);

  assert_drive_on_low_clock_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !$past(scl_s));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int BLK_BITS   = 1;
  localparam int MSIZE      = 1 << (8 + BLK_BITS);

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic oe;
  wire  sda_bus = sda_m & ~oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [MSIZE];
  bit         valid [MSIZE];
  logic [7:0] mptr = 8'h00;

  i2c_eeprom_slave #(.BLK_BITS(BLK_BITS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .pins_i(pins), .wp_i(wp), .sda_oe_o(oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // R9: the drive may only switch on while the bus clock is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && oe && !oe_prev && scl) chk(1'b0, "R9 drive while SCL high", 1, 0);
    oe_prev <= oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q);
    s = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit nack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, nack);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  function automatic logic [7:0] sel(input bit blk, input bit rd);
    return {4'b1010, pins[2], pins[1], blk, rd};
  endfunction

  function automatic int idx(input bit blk, input logic [7:0] a);
    return int'({blk, a});
  endfunction

  task automatic write_tx(input bit blk, input logic [7:0] a, input int n,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3);
    bit nk;
    logic [7:0] dat [4];
    dat[0] = d0; dat[1] = d1; dat[2] = d2; dat[3] = d3;
    bus_start;
    send_byte(sel(blk, 1'b0), nk); chk(nk == 1'b0, "R5 select ack (write)", nk, 0);
    send_byte(a, nk);              chk(nk == 1'b0, "R6 pointer ack", nk, 0);
    mptr = a;
    for (int i = 0; i < n; i++) begin
      send_byte(dat[i], nk);
      chk(nk == 1'b0, "R6/R8 data ack", nk, 0);
      if (!wp) begin
        model[idx(blk, mptr)] = dat[i];
        valid[idx(blk, mptr)] = 1'b1;
      end
      mptr = mptr + 8'd1;
    end
    bus_stop;
  endtask

  task automatic read_tx(input bit blk, input logic [7:0] a, input int n, input string tag);
    bit nk;
    logic [7:0] d;
    bus_start;
    send_byte(sel(blk, 1'b0), nk); chk(nk == 1'b0, "R5 select ack (dummy write)", nk, 0);
    send_byte(a, nk);              chk(nk == 1'b0, "R6 pointer ack", nk, 0);
    mptr = a;
    bus_start;
    send_byte(sel(blk, 1'b1), nk); chk(nk == 1'b0, "R3 read select ack", nk, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      if (valid[idx(blk, mptr)])
        chk(d == model[idx(blk, mptr)], tag, d, model[idx(blk, mptr)]);
      mptr = mptr + 8'd1;
    end
    chk(oe == 1'b0, "R7 released after master nack", oe, 0);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run;
  end

  initial begin
    bit nk;
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < MSIZE; i++) valid[i] = 1'b0;
    tick(4);
    chk(oe == 1'b0, "R10 released in reset", oe, 0);
    rst = 1'b0;
    tick(4);
    chk(oe == 1'b0, "R10 released after reset", oe, 0);

    // R1: a byte with no START in front of it is ignored
    send_byte(sel(1'b0, 1'b0), nk);
    chk(nk == 1'b1, "R1 no ack without START", nk, 1);
    bus_stop;

    // R6: write across the 0xFF wrap within block 0
    write_tx(1'b0, 8'hFE, 3, 8'h11, 8'h22, 8'h33, 8'h00);
    read_tx(1'b0, 8'hFE, 3, "R6 wrap readback");
    chk(valid[idx(1'b0, 8'h00)] && model[idx(1'b0, 8'h00)] == 8'h33, "R6 wrap target", 0, 0);

    // R4: block bit A0 picks the second block
    write_tx(1'b1, 8'hFE, 1, 8'h44, 8'h00, 8'h00, 8'h00);
    read_tx(1'b1, 8'hFE, 1, "R4 block 1 readback");
    read_tx(1'b0, 8'hFE, 1, "R4 block 0 untouched");

    // R4: A2 differs from its pin, silent until next START
    bus_start;
    send_byte({4'b1010, ~pins[2], pins[1], 1'b0, 1'b0}, nk);
    chk(nk == 1'b1, "R4 pin mismatch nack", nk, 1);
    send_byte(8'h00, nk);
    chk(nk == 1'b1, "R4 silent after mismatch", nk, 1);
    bus_start;
    send_byte({4'b1010, pins[2], ~pins[1], 1'b0, 1'b1}, nk);
    chk(nk == 1'b1, "R4 A1 mismatch nack", nk, 1);
    bus_stop;

    // R3: wrong type code
    bus_start;
    send_byte({4'b1011, pins[2], pins[1], 1'b0, 1'b0}, nk);
    chk(nk == 1'b1, "R3 type code mismatch nack", nk, 1);
    bus_stop;

    // R8: protected write is acked, contents unchanged
    wp = 1'b1;
    write_tx(1'b0, 8'hFE, 2, 8'h99, 8'h98, 8'h00, 8'h00);
    wp = 1'b0;
    read_tx(1'b0, 8'hFE, 2, "R8 protected contents");

    // R2 / R7: pointer set, STOP, then current-address read
    write_tx(1'b0, 8'h10, 2, 8'h5A, 8'hA5, 8'h00, 8'h00);
    bus_start;
    send_byte(sel(1'b0, 1'b0), nk);
    send_byte(8'h10, nk);
    bus_stop;
    chk(oe == 1'b0, "R2 released after STOP", oe, 0);
    bus_start;
    send_byte(sel(1'b0, 1'b1), nk);
    chk(nk == 1'b0, "R7 current read ack", nk, 0);
    recv_byte(1'b1, d);
    chk(d == 8'h5A, "R2 R7 current address byte", d, 8'h5A);
    recv_byte(1'b0, d);
    chk(d == 8'hA5, "R7 sequential byte", d, 8'hA5);
    chk(oe == 1'b0, "R7 released after nack", oe, 0);
    bus_stop;

    // random write/readback mix
    for (int it = 0; it < 14; it++) begin
      bit b = 1'($urandom);
      logic [7:0] a = 8'($urandom);
      int n = 1 + int'($urandom % 4);
      write_tx(b, a, n, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      read_tx(b, a, n, "R6 R7 random readback");
    end

    finish_run;
  end
endmodule